// File: doc/BRIEF.md
# Low-Power Mode and Wake-up Controller

This block sequences an 8-bit microcontroller core between three operating states: normal run, idle (CPU clock stopped, interrupt, timer and serial clocks alive) and power-down (high-frequency oscillator stopped). It takes the two mode-request strobes written by software, the watchdog enable, the two external interrupt lines with their trigger-mode and enable settings, the seconds-timer interrupt, and a summary of the interrupt controller's state. From these it produces clock-gating enables, the oscillator run enable and a set of pin-override controls that the pad ring applies while the core is stopped.

Leaving power-down goes through an oscillator-restart state. The controller restarts the oscillator and counts a parameterised settling time before releasing the CPU clock. If the wake-up condition goes away before that count completes, the controller falls back to power-down. At the end of the settling time, the controller returns to run, unless an interrupt of equal or higher priority than the wake-up source is already in service. In that case it parks in idle until a strictly higher-priority request arrives. The block runs on an always-on control clock, and its synchronous reset stands for the chip's external reset.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: When reset is active at a clock edge, the next state is run (state_oh = 4'b0001) with mode_idle = mode_pd = 0. In that state cpu_clk_en, per_clk_en and hfosc_en are all 1, and no pin override is active.
- R2: In run, a pd_req with wdt_en = 0 enters power-down on the next edge and sets mode_pd. In power-down hfosc_en, cpu_clk_en and per_clk_en are all 0. If pd_req and idle_req arrive together, pd_req wins.
- R3: While wdt_en = 1, pd_req has no effect. The state stays run, unless idle_req is also present, in which case it goes to idle.
- R4: In run, idle_req without an accepted pd_req enters idle and sets mode_idle. In idle cpu_clk_en = 0 while per_clk_en = 1 and hfosc_en = 1.
- R5: In power-down, a wake event is any of three conditions: an external line (ext0_n or ext1_n) is low while its enable is 1 and its trigger-mode bit is 1 (level); or sec_irq = 1 while sec_en = 1 and ext1_lvl = 1. An edge-configured (trigger-mode bit 0) or disabled source never wakes the device.
- R6: A wake event moves power-down to the oscillator-wait state (state_oh = 4'b1000). In that state hfosc_en = 1, cpu_clk_en = 0 and per_clk_en = 0. The state is held for exactly STAB_CYCLES edges while the wake event persists. If the wake event is absent at any edge in this state, the controller returns to power-down.
- R7: When the wait completes, the controller checks whether in_svc = 1 and svc_prio >= wake_prio. If so, it enters idle with mode_idle = 1 and mode_pd = 0. Otherwise it enters run with both mode bits cleared.
- R8: Idle is left for run, with both mode bits cleared, when irq_pend = 1 and either in_svc = 0 or irq_prio > svc_prio. Otherwise the state stays idle.
- R9: ALE and PSEN are overridden (ale_psen_force = 1) in every state except run. The forced level ale_psen_val is 1 in idle and 0 in power-down and oscillator wait.
- R10: With ext_mem = 1, port 0 is released (p0_hiz = 1) in every state except run. Port 2 selects its register data (p2_sfr_sel = 1) only in power-down and oscillator wait, and keeps the address in idle. With ext_mem = 0 both are 0.
- R11: The serial bus pins are released (ser_hiz = 1) in power-down and oscillator wait, and in idle when sio_en = 0. pwm_force_hi = 1 in every state except run.
- R12: state_oh always has exactly one bit set: bit 0 run, bit 1 idle, bit 2 power-down, bit 3 oscillator wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Synchronous active-low reset (external reset) |
| idle_req | input | 1 | Idle request strobe from the power control register |
| pd_req | input | 1 | Power-down request strobe from the power control register |
| wdt_en | input | 1 | Watchdog enabled; blocks power-down |
| ext0_n | input | 1 | External interrupt line 0, active low |
| ext0_lvl | input | 1 | Line 0 trigger mode, 1 = level |
| ext0_en | input | 1 | Line 0 interrupt enable |
| ext1_n | input | 1 | External interrupt line 1, active low |
| ext1_lvl | input | 1 | Line 1 trigger mode, 1 = level |
| ext1_en | input | 1 | Line 1 interrupt enable |
| sec_irq | input | 1 | Seconds-timer interrupt request |
| sec_en | input | 1 | Seconds-timer interrupt enable |
| wake_prio | input | PRIO_W | Priority level of the wake-up interrupt sources |
| in_svc | input | 1 | An interrupt is currently in service |
| svc_prio | input | PRIO_W | Priority of the in-service interrupt |
| irq_pend | input | 1 | An enabled interrupt request is pending |
| irq_prio | input | PRIO_W | Priority of the pending request |
| ext_mem | input | 1 | Core fetches from external program memory |
| sio_en | input | 1 | Serial bus unit enabled |
| state_oh | output | 4 | One-hot state: run, idle, power-down, oscillator wait |
| mode_idle | output | 1 | Idle mode bit |
| mode_pd | output | 1 | Power-down mode bit |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Interrupt, timer and serial clock enable |
| hfosc_en | output | 1 | High-frequency oscillator run enable |
| ale_psen_force | output | 1 | Override ALE and PSEN pins |
| ale_psen_val | output | 1 | Level forced on ALE and PSEN |
| p0_hiz | output | 1 | Release port 0 to high impedance |
| p2_sfr_sel | output | 1 | Port 2 drives register data instead of address |
| ser_hiz | output | 1 | Release serial bus pins |
| pwm_force_hi | output | 1 | Force PWM outputs high |

## Verification
On every cycle the assertions check four things. The state vector stays one-hot. The watchdog keeps power-down out of reach. The oscillator-wait state is entered only from power-down. An edge-configured source never raises a wake event. They also bound the settling counter and tie the idle-hold and priority-routing decisions to the next state. Only the bench scenarios can show three further behaviours: that the wait lasts exactly the configured number of cycles; that a wake line dropped part-way through the wait returns to power-down; and that the pin overrides follow the state and the external-memory and serial-enable inputs across long random runs with resets mixed in.

// File: rtl/pwr_mode_pkg.sv
// Package: shared state encoding for the low-power mode controller.
// Assumes the one-hot bit order below is what the pad and clock logic decode.
package pwr_mode_pkg;

    localparam int ST_W = 4;

    // One-hot state encoding; bit positions are part of the port contract.
    typedef enum logic [ST_W-1:0] {
        ST_RUN  = 4'b0001,
        ST_IDLE = 4'b0010,
        ST_PD   = 4'b0100,
        ST_WAIT = 4'b1000
    } pm_state_t;

endpackage

// File: rtl/pwr_wake_qual.sv
// Module: qualifies wake-up sources for leaving power-down.
// Assumes external lines are active low and already synchronised to clk.
module pwr_wake_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic ext0_n,
    input  logic ext0_lvl,
    input  logic ext0_en,
    input  logic ext1_n,
    input  logic ext1_lvl,
    input  logic ext1_en,
    input  logic sec_irq,
    input  logic sec_en,
    output logic wake
);

    logic w0, w1, ws;

    // Per-source qualification: only enabled, level-configured sources count.
    always_comb begin
        w0   = ext0_en & ext0_lvl & ~ext0_n;
        w1   = ext1_en & ext1_lvl & ~ext1_n;
        ws   = sec_en  & ext1_lvl & sec_irq;
        wake = w0 | w1 | ws;
    end

    // R5: with both lines edge-configured nothing can wake the device.
    a_r5_edge_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext0_lvl && !ext1_lvl) |-> !wake);

endmodule

// File: rtl/pwr_stab_cnt.sv
// Module: oscillator settling counter.
// Assumes STAB_CYCLES >= 2; done is high in the last of STAB_CYCLES counted cycles.
module pwr_stab_cnt #(
    parameter int STAB_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    output logic done
);

    localparam int CNT_W = $clog2(STAB_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Counter: clears whenever counting is not requested, otherwise advances.
    always_ff @(posedge clk) begin
        if (!rst_n || !count_en)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    // Terminal-count decode.
    always_comb done = (cnt == LAST);

    // R6: the counter never passes its last value.
    a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/pwr_pin_ctrl.sv
// Module: pad override controls derived from the operating state.
// Assumes the pad ring applies each override only while its control is high.
module pwr_pin_ctrl
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pm_state_t state,
    input  logic      ext_mem,
    input  logic      sio_en,
    output logic      ale_psen_force,
    output logic      ale_psen_val,
    output logic      p0_hiz,
    output logic      p2_sfr_sel,
    output logic      ser_hiz,
    output logic      pwm_force_hi
);

    logic is_run, is_idle, is_stop;

    // State decode: wait behaves like power-down on the pins.
    always_comb begin
        is_run  = (state == ST_RUN);
        is_idle = (state == ST_IDLE);
        is_stop = (state == ST_PD) || (state == ST_WAIT);
    end

    // Override generation.
    always_comb begin
        ale_psen_force = ~is_run;
        ale_psen_val   = is_idle;
        p0_hiz         = ext_mem & ~is_run;
        p2_sfr_sel     = ext_mem & is_stop;
        ser_hiz        = is_stop | (is_idle & ~sio_en);
        pwm_force_hi   = ~is_run;
    end

    // R10: port 2 never holds register data while port 0 drives in run.
    a_r10_p2_only_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        p2_sfr_sel |-> p0_hiz);

    // R9: the forced ALE/PSEN level is high only when the override is active.
    a_r9_val_needs_force: assert property (@(posedge clk) disable iff (!rst_n)
        ale_psen_val |-> ale_psen_force);

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Module: run/idle/power-down sequencer with oscillator restart wait.
// Assumes clk is an always-on control clock, independent of the gated HF oscillator,
// and that rst_n is the synchronised external reset.
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int STAB_CYCLES = 1024,
    parameter int PRIO_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle_req,
    input  logic              pd_req,
    input  logic              wdt_en,
    input  logic              ext0_n,
    input  logic              ext0_lvl,
    input  logic              ext0_en,
    input  logic              ext1_n,
    input  logic              ext1_lvl,
    input  logic              ext1_en,
    input  logic              sec_irq,
    input  logic              sec_en,
    input  logic [PRIO_W-1:0] wake_prio,
    input  logic              in_svc,
    input  logic [PRIO_W-1:0] svc_prio,
    input  logic              irq_pend,
    input  logic [PRIO_W-1:0] irq_prio,
    input  logic              ext_mem,
    input  logic              sio_en,
    output logic [ST_W-1:0]   state_oh,
    output logic              mode_idle,
    output logic              mode_pd,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              hfosc_en,
    output logic              ale_psen_force,
    output logic              ale_psen_val,
    output logic              p0_hiz,
    output logic              p2_sfr_sel,
    output logic              ser_hiz,
    output logic              pwm_force_hi
);

    pm_state_t state, state_nx;
    logic      idle_nx, pd_nx;
    logic      wake, stab_done, cnt_en;
    logic      svc_blocks, idle_exit, pd_ok;

    pwr_wake_qual u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext0_n   (ext0_n),
        .ext0_lvl (ext0_lvl),
        .ext0_en  (ext0_en),
        .ext1_n   (ext1_n),
        .ext1_lvl (ext1_lvl),
        .ext1_en  (ext1_en),
        .sec_irq  (sec_irq),
        .sec_en   (sec_en),
        .wake     (wake)
    );

    pwr_stab_cnt #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (cnt_en),
        .done     (stab_done)
    );

    pwr_pin_ctrl u_pins (
        .clk            (clk),
        .rst_n          (rst_n),
        .state          (state),
        .ext_mem        (ext_mem),
        .sio_en         (sio_en),
        .ale_psen_force (ale_psen_force),
        .ale_psen_val   (ale_psen_val),
        .p0_hiz         (p0_hiz),
        .p2_sfr_sel     (p2_sfr_sel),
        .ser_hiz        (ser_hiz),
        .pwm_force_hi   (pwm_force_hi)
    );

    // Decision terms: watchdog gate, in-service priority block, idle exit.
    always_comb begin
        pd_ok      = pd_req & ~wdt_en;
        svc_blocks = in_svc & (svc_prio >= wake_prio);
        idle_exit  = irq_pend & (~in_svc | (irq_prio > svc_prio));
        cnt_en     = (state == ST_WAIT) & wake;
    end

    // Next-state and mode-bit logic.
    always_comb begin
        state_nx = state;
        idle_nx  = mode_idle;
        pd_nx    = mode_pd;
        unique case (state)
            ST_RUN: begin
                if (pd_ok) begin
                    state_nx = ST_PD;
                    pd_nx    = 1'b1;
                    idle_nx  = 1'b0;
                end else if (idle_req) begin
                    state_nx = ST_IDLE;
                    idle_nx  = 1'b1;
                end
            end
            ST_IDLE: begin
                if (idle_exit) begin
                    state_nx = ST_RUN;
                    idle_nx  = 1'b0;
                    pd_nx    = 1'b0;
                end
            end
            ST_PD: begin
                if (wake) state_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (!wake) begin
                    state_nx = ST_PD;
                end else if (stab_done) begin
                    pd_nx = 1'b0;
                    if (svc_blocks) begin
                        state_nx = ST_IDLE;
                        idle_nx  = 1'b1;
                    end else begin
                        state_nx = ST_RUN;
                        idle_nx  = 1'b0;
                    end
                end
            end
            default: state_nx = ST_RUN;
        endcase
    end

    // State and mode-bit registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_RUN;
            mode_idle <= 1'b0;
            mode_pd   <= 1'b0;
        end else begin
            state     <= state_nx;
            mode_idle <= idle_nx;
            mode_pd   <= pd_nx;
        end
    end

    // Clock and oscillator enables per state.
    always_comb begin
        state_oh   = state;
        cpu_clk_en = (state == ST_RUN);
        per_clk_en = (state == ST_RUN) || (state == ST_IDLE);
        hfosc_en   = (state != ST_PD);
    end

    // R12: exactly one state bit.
    a_r12_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_oh) == 1);

    // R3: watchdog keeps the core out of power-down.
    a_r3_wdt_blocks_pd: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[0] && wdt_en) |=> !state_oh[2]);

    // R6: oscillator wait is only ever entered from power-down.
    a_r6_wait_from_pd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_oh[3]) |-> $past(state_oh[2]));

    // R7: completed wait with a blocking in-service interrupt lands in idle.
    a_r7_blocked_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[3] && wake && stab_done && svc_blocks) |=> (state_oh[1] && mode_idle && !mode_pd));

    // R8: idle holds while no request is pending.
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[1] && !irq_pend) |=> state_oh[1]);

endmodule

// File: tb/sim_pwr_mode_ctrl.sv
// Bench: directed corner cases then seeded random stimulus, checked against a
// cycle model written from the requirements.
module sim_pwr_mode_ctrl;

    localparam int NSTAB = 8;
    localparam int PW    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic idle_req = 0, pd_req = 0, wdt_en = 0;
    logic ext0_n = 1, ext0_lvl = 0, ext0_en = 0;
    logic ext1_n = 1, ext1_lvl = 0, ext1_en = 0;
    logic sec_irq = 0, sec_en = 0;
    logic [PW-1:0] wake_prio = 0, svc_prio = 0, irq_prio = 0;
    logic in_svc = 0, irq_pend = 0, ext_mem = 0, sio_en = 0;

    logic [3:0] state_oh;
    logic mode_idle, mode_pd, cpu_clk_en, per_clk_en, hfosc_en;
    logic ale_psen_force, ale_psen_val, p0_hiz, p2_sfr_sel, ser_hiz, pwm_force_hi;

    int n_chk = 0, n_bad = 0;

    // Model state: 0 run, 1 idle, 2 power-down, 3 wait.
    int m_st = 0, m_cnt = 0;
    logic m_idle = 0, m_pd = 0;

    always #10 clk = ~clk;

    pwr_mode_ctrl #(.STAB_CYCLES(NSTAB), .PRIO_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .pd_req(pd_req), .wdt_en(wdt_en),
        .ext0_n(ext0_n), .ext0_lvl(ext0_lvl), .ext0_en(ext0_en),
        .ext1_n(ext1_n), .ext1_lvl(ext1_lvl), .ext1_en(ext1_en),
        .sec_irq(sec_irq), .sec_en(sec_en), .wake_prio(wake_prio),
        .in_svc(in_svc), .svc_prio(svc_prio), .irq_pend(irq_pend), .irq_prio(irq_prio),
        .ext_mem(ext_mem), .sio_en(sio_en), .state_oh(state_oh),
        .mode_idle(mode_idle), .mode_pd(mode_pd), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .hfosc_en(hfosc_en), .ale_psen_force(ale_psen_force),
        .ale_psen_val(ale_psen_val), .p0_hiz(p0_hiz), .p2_sfr_sel(p2_sfr_sel),
        .ser_hiz(ser_hiz), .pwm_force_hi(pwm_force_hi)
    );

    function automatic logic model_wake();
        return (ext0_en & ext0_lvl & ~ext0_n) | (ext1_en & ext1_lvl & ~ext1_n)
             | (sec_en & ext1_lvl & sec_irq);
    endfunction

    // Advance the model by one clock edge using the inputs now applied.
    task automatic model_step();
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_idle = 0; m_pd = 0;
        end else begin
            case (m_st)
                0: if (pd_req && !wdt_en) begin m_st = 2; m_pd = 1; m_idle = 0; end
                   else if (idle_req) begin m_st = 1; m_idle = 1; end
                1: if (irq_pend && (!in_svc || irq_prio > svc_prio)) begin
                       m_st = 0; m_idle = 0; m_pd = 0;
                   end
                2: if (model_wake()) begin m_st = 3; m_cnt = 0; end
                default: begin
                    if (!model_wake()) begin m_st = 2; m_cnt = 0; end
                    else if (m_cnt == NSTAB - 1) begin
                        m_cnt = 0; m_pd = 0;
                        if (in_svc && svc_prio >= wake_prio) begin m_st = 1; m_idle = 1; end
                        else begin m_st = 0; m_idle = 0; end
                    end else m_cnt++;
                end
            endcase
        end
    endtask

    task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model state.
    task automatic check_all();
        logic run, idl, pd, wt;
        run = (m_st == 0); idl = (m_st == 1); pd = (m_st == 2); wt = (m_st == 3);
        cmp("R12 state_oh", {4'b0, state_oh}, {4'b0, wt, pd, idl, run});
        cmp("R7 mode bits", {6'b0, mode_idle, mode_pd}, {6'b0, m_idle, m_pd});
        cmp("R2 clock enables", {5'b0, cpu_clk_en, per_clk_en, hfosc_en},
            {5'b0, run, run | idl, ~pd});
        cmp("R9 ale/psen", {6'b0, ale_psen_force, ale_psen_val}, {6'b0, ~run, idl});
        cmp("R10 port0/port2", {6'b0, p0_hiz, p2_sfr_sel},
            {6'b0, ext_mem & ~run, ext_mem & (pd | wt)});
        cmp("R11 serial/pwm", {6'b0, ser_hiz, pwm_force_hi},
            {6'b0, pd | wt | (idl & ~sio_en), ~run});
    endtask

    task automatic tick();
        model_step();
        @(negedge clk);
        check_all();
    endtask

    task automatic expect_st(input string tag, input logic [3:0] exp);
        cmp(tag, {4'b0, state_oh}, {4'b0, exp});
    endtask

    task automatic go_pd();
        pd_req = 1; tick(); pd_req = 0;
    endtask

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        tick(); tick();
        expect_st("R1 reset to run", 4'b0001);
        cmp("R1 enables after reset", {5'b0, cpu_clk_en, per_clk_en, hfosc_en}, 8'b111);
        rst_n = 1; tick();

        // R3: watchdog blocks power-down; idle still honoured.
        wdt_en = 1; pd_req = 1; tick();
        expect_st("R3 pd ignored with watchdog", 4'b0001);
        idle_req = 1; tick(); pd_req = 0; idle_req = 0;
        expect_st("R3 idle taken with watchdog", 4'b0010);
        irq_pend = 1; tick(); irq_pend = 0; wdt_en = 0;
        expect_st("R8 idle exit no svc", 4'b0001);

        // R2: pd wins over idle.
        pd_req = 1; idle_req = 1; tick(); pd_req = 0; idle_req = 0;
        expect_st("R2 pd beats idle", 4'b0100);
        cmp("R2 oscillator off", {7'b0, hfosc_en}, 8'b0);

        // R5: edge-configured line does not wake.
        ext0_en = 1; ext0_lvl = 0; ext0_n = 0; tick(); tick();
        expect_st("R5 edge line no wake", 4'b0100);
        sec_en = 1; sec_irq = 1; ext1_lvl = 0; tick();
        expect_st("R5 seconds needs ext1 level", 4'b0100);
        sec_en = 0; ext1_lvl = 1; tick();
        expect_st("R5 disabled seconds no wake", 4'b0100);
        sec_en = 1; tick();
        expect_st("R5 seconds wakes", 4'b1000);
        sec_irq = 0; tick();
        expect_st("R6 dropped wake back to pd", 4'b0100);
        sec_en = 0; sec_irq = 0; ext1_lvl = 0;

        // R6: level line wakes, wait length exact, R7 priority to idle.
        ext0_lvl = 1; in_svc = 1; svc_prio = 2; wake_prio = 1; tick();
        expect_st("R6 wait entered", 4'b1000);
        cmp("R6 oscillator on in wait", {7'b0, hfosc_en}, 8'b1);
        for (int k = 0; k < NSTAB - 1; k++) tick();
        expect_st("R6 still waiting", 4'b1000);
        tick();
        expect_st("R7 blocked wake goes idle", 4'b0010);
        ext0_n = 1;
        irq_pend = 1; irq_prio = 2; tick();
        expect_st("R8 equal prio stays idle", 4'b0010);
        irq_prio = 3; tick();
        expect_st("R8 higher prio exits idle", 4'b0001);
        irq_pend = 0; in_svc = 0; ext0_en = 0; ext0_lvl = 0;

        // R4 and R10/R11 pins in idle with external memory.
        ext_mem = 1; sio_en = 1; idle_req = 1; tick(); idle_req = 0;
        expect_st("R4 idle entered", 4'b0010);
        cmp("R10 port2 keeps address in idle", {7'b0, p2_sfr_sel}, 8'b0);
        cmp("R11 serial active in idle", {7'b0, ser_hiz}, 8'b0);
        irq_pend = 1; tick(); irq_pend = 0;

        // Random phase with sticky inputs.
        for (int i = 0; i < 6000; i++) begin
            rst_n    = ($urandom_range(0, 399) != 0);
            idle_req = ($urandom_range(0, 15) == 0);
            pd_req   = ($urandom_range(0, 11) == 0);
            if ($urandom_range(0, 31) == 0) wdt_en = ~wdt_en;
            if ($urandom_range(0, 11) == 0) ext0_n = ~ext0_n;
            if ($urandom_range(0, 11) == 0) ext1_n = ~ext1_n;
            if ($urandom_range(0, 19) == 0) ext0_lvl = ~ext0_lvl;
            if ($urandom_range(0, 19) == 0) ext1_lvl = ~ext1_lvl;
            if ($urandom_range(0, 19) == 0) ext0_en = ~ext0_en;
            if ($urandom_range(0, 19) == 0) ext1_en = ~ext1_en;
            if ($urandom_range(0, 11) == 0) sec_irq = ~sec_irq;
            if ($urandom_range(0, 19) == 0) sec_en = ~sec_en;
            if ($urandom_range(0, 15) == 0) in_svc = ~in_svc;
            if ($urandom_range(0, 15) == 0) svc_prio = PW'($urandom);
            if ($urandom_range(0, 15) == 0) wake_prio = PW'($urandom);
            irq_pend = ($urandom_range(0, 5) == 0);
            irq_prio = PW'($urandom);
            if ($urandom_range(0, 31) == 0) ext_mem = ~ext_mem;
            if ($urandom_range(0, 31) == 0) sio_en = ~sio_en;
            tick();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule